// File: doc/BRIEF.md
# Packed-BCD Capable 8-bit ALU with Flag Register

This block is the arithmetic core of a small 8-bit processor. It combines two 8-bit operands under a 4-bit operation code and produces an 8-bit result in the same cycle. Alongside the result it gives a write-enable that tells the surrounding datapath whether the result should be stored. A clocked flag register holds the condition codes. When `exec` is high, the register updates on the rising clock edge.

The operations are the three bitwise logic functions, two's-complement negate, add, subtract, compare and a decimal-adjust step. Decimal adjust turns the raw binary sum of two packed-BCD bytes into a valid packed-BCD byte. It reads the half-carry and carry flags left by the preceding add. The flag register is always presented as a full byte, and its two spare bits are held at one. Two further codes set or clear the interrupt-mask flag.

Top module: `bcd_alu8`

## Requirements
- R1: The flag byte `ccr` has bit 7 and bit 6 always at 1, H at bit 5, I at bit 4, N at bit 3, Z at bit 2, V at bit 1 and C at bit 0. After reset it reads 0xD0 (I set, all other flags clear).
- R2: Operation codes are: 0 AND, 1 OR, 2 XOR, 3 NEG (of `opa`), 4 CMP, 5 ADD, 6 SUB, 7 DAA (of `opa`), 8 set I, 9 clear I. Codes 10 to 15 are unused. `result` is combinational, and for unused codes, 8 and 9 it is 0x00.
- R3: `res_we` is high only when `exec` is high and the code is one of AND, OR, XOR, NEG, ADD, SUB or DAA. It is low for CMP, for codes 8 to 15 and whenever `exec` is low.
- R4: AND/OR/XOR give the bitwise function of `opa` and `opb`, clear V, and leave C and H unchanged.
- R5: ADD gives `opa+opb` mod 256. C is the carry out of bit 7, H is the carry out of bit 3, and V flags signed overflow.
- R6: SUB and CMP compute `opa-opb` mod 256. C is set when `opa < opb` unsigned, V flags signed overflow, and H is unchanged.
- R7: NEG gives `0-opa` mod 256. C is set when the result is non-zero, V is set when the result is 0x80, and H is unchanged.
- R8: DAA adds 0x06 when the low nibble of `opa` exceeds 9 or H is set. It adds 0x60 when the high nibble exceeds 9, or C is set, or the high nibble equals 9 while the low nibble exceeds 9. The new C is the old C OR the upper correction. V and H are unchanged.
- R9: With `exec` high, code 8 sets I and code 9 clears I. Neither changes any other flag.
- R10: The flag register holds its value when `exec` is low, and when `exec` is high with an unused code.
- R11: For every operation with codes 0 to 7, N takes bit 7 of the result and Z is set exactly when the result is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the flag register updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| exec | input | 1 | Perform the operation on the coming edge |
| op | input | 4 | Operation code |
| opa | input | 8 | First operand (sole operand for NEG and DAA) |
| opb | input | 8 | Second operand |
| result | output | 8 | Combinational result |
| res_we | output | 1 | Result should be written back |
| ccr | output | 8 | Flag register as a byte |

## Verification
The assertions assume that `op`, `opa` and `opb` are steady and known around each rising edge. They also assume `exec` is never unknown after reset, because the flag properties compare the flags with `$past` operands. The stimulus meets this by changing every input only at falling edges. Reset stays asserted through the first edges, so every `$past` sample the properties read after reset is a driven value. Random runs draw operation codes from the full 4-bit range, so unused codes and idle cycles appear among the legal ones. Decimal adjust is also run right after adds of valid packed-BCD bytes, so that it sees the half-carry it expects.

// File: rtl/bcd_alu8.sv
module bcd_alu8 (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       exec,
  input  logic [3:0] op,
  input  logic [7:0] opa,
  input  logic [7:0] opb,
  output logic [7:0] result,
  output logic       res_we,
  output logic [7:0] ccr
);
  localparam logic [3:0] OP_AND = 4'd0;
  localparam logic [3:0] OP_OR  = 4'd1;
  localparam logic [3:0] OP_XOR = 4'd2;
  localparam logic [3:0] OP_NEG = 4'd3;
  localparam logic [3:0] OP_CMP = 4'd4;
  localparam logic [3:0] OP_ADD = 4'd5;
  localparam logic [3:0] OP_SUB = 4'd6;
  localparam logic [3:0] OP_DAA = 4'd7;
  localparam logic [3:0] OP_SEI = 4'd8;
  localparam logic [3:0] OP_CLI = 4'd9;

  logic fh, fi, fn, fz, fv, fc;
  logic nh, ni, nn, nz, nv, nc, upd;

  assign ccr = {2'b11, fh, fi, fn, fz, fv, fc};

  logic [8:0] sum9, dif9;
  logic [4:0] lo5;
  logic [7:0] neg8, daa8;
  logic       adj_lo, adj_hi;

  assign sum9   = {1'b0, opa} + {1'b0, opb};
  assign dif9   = {1'b0, opa} - {1'b0, opb};
  assign lo5    = {1'b0, opa[3:0]} + {1'b0, opb[3:0]};
  assign neg8   = 8'h00 - opa;
  assign adj_lo = (opa[3:0] > 4'd9) | fh;
  assign adj_hi = (opa[7:4] > 4'd9) | fc | ((opa[7:4] == 4'd9) & (opa[3:0] > 4'd9));
  assign daa8   = opa + {1'b0, adj_hi, adj_hi, 2'b00, adj_lo, adj_lo, 1'b0};

  always_comb begin
    result = 8'h00;
    res_we = 1'b0;
    upd    = 1'b1;
    nh = fh; ni = fi; nv = fv; nc = fc;
    case (op)
      OP_AND: begin result = opa & opb; res_we = 1'b1; nv = 1'b0; end
      OP_OR:  begin result = opa | opb; res_we = 1'b1; nv = 1'b0; end
      OP_XOR: begin result = opa ^ opb; res_we = 1'b1; nv = 1'b0; end
      OP_NEG: begin
        result = neg8; res_we = 1'b1;
        nc = (neg8 != 8'h00); nv = (neg8 == 8'h80);
      end
      OP_CMP, OP_SUB: begin
        result = dif9[7:0]; res_we = (op == OP_SUB);
        nc = dif9[8]; nv = (opa[7] ^ opb[7]) & (dif9[7] ^ opa[7]);
      end
      OP_ADD: begin
        result = sum9[7:0]; res_we = 1'b1;
        nc = sum9[8]; nh = lo5[4]; nv = ~(opa[7] ^ opb[7]) & (sum9[7] ^ opa[7]);
      end
      OP_DAA: begin result = daa8; res_we = 1'b1; nc = fc | adj_hi; end
      OP_SEI: ni = 1'b1;
      OP_CLI: ni = 1'b0;
      default: upd = 1'b0;
    endcase
    res_we = res_we & exec;
    if (op[3]) begin
      nn = fn; nz = fz;
    end else begin
      nn = result[7]; nz = (result == 8'h00);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {fh, fi, fn, fz, fv, fc} <= 6'b010000;
    end else if (exec && upd) begin
      {fh, fi, fn, fz, fv, fc} <= {nh, ni, nn, nz, nv, nc};
    end
  end
endmodule

// File: rtl/bcd_alu8_chk.sv
module bcd_alu8_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       exec,
  input logic [3:0] op,
  input logic [7:0] opa,
  input logic [7:0] opb,
  input logic [7:0] result,
  input logic       res_we,
  input logic [7:0] ccr
);
  // R1
  spare_ones_chk: assert property (@(posedge clk) disable iff (!rst_n) ccr[7:6] == 2'b11);
  // R3
  idle_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n) !exec |-> !res_we);
  // R3
  cmp_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n) (op == 4'd4) |-> !res_we);
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !exec |=> $stable(ccr));
  // R4
  logic_v_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op <= 4'd2) |=> (ccr[1] == 1'b0 && ccr[0] == $past(ccr[0]) && ccr[5] == $past(ccr[5])));
  // R5
  add_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd5) |=> ccr[5] == ($past({1'b0, opa[3:0]} + {1'b0, opb[3:0]}) > 5'd15));
  // R11
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && !op[3]) |=> ccr[2] == ($past(result) == 8'h00));
  // R9
  sei_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (exec && op == 4'd8) |=> (ccr[4] && ccr[5] == $past(ccr[5]) && ccr[3:0] == $past(ccr[3:0])));
endmodule

bind bcd_alu8 bcd_alu8_chk chk_i (
  .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opa(opa), .opb(opb),
  .result(result), .res_we(res_we), .ccr(ccr)
);

// File: tb/bcd_alu8_tb_top.sv
module bcd_alu8_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       exec = 1'b0;
  logic [3:0] op = 4'd0;
  logic [7:0] opa = 8'h00;
  logic [7:0] opb = 8'h00;
  logic [7:0] result;
  logic       res_we;
  logic [7:0] ccr;

  int checks = 0;
  int errors = 0;
  int m_ccr = 'hD0;

  always #4 clk = ~clk;

  bcd_alu8 dut_i (
    .clk(clk), .rst_n(rst_n), .exec(exec), .op(op), .opa(opa), .opb(opb),
    .result(result), .res_we(res_we), .ccr(ccr)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  function automatic void model(input int e, input int o, input int a, input int b, input int f,
                                output int r, output int we, output int nf);
    int h, i, n, z, v, c, wr, upd, lo, hi, cl, ch;
    h = (f >> 5) & 1; i = (f >> 4) & 1; n = (f >> 3) & 1;
    z = (f >> 2) & 1; v = (f >> 1) & 1; c = f & 1;
    r = 0; wr = 0; upd = 1;
    case (o)
      0: begin r = a & b; wr = 1; v = 0; end
      1: begin r = a | b; wr = 1; v = 0; end
      2: begin r = a ^ b; wr = 1; v = 0; end
      3: begin r = (256 - a) % 256; wr = 1; c = (r != 0); v = (r == 128); end
      4, 6: begin
        r = (a - b + 256) % 256; wr = (o == 6); c = (a < b);
        v = (((a >= 128) != (b >= 128)) && ((r >= 128) != (a >= 128)));
      end
      5: begin
        r = (a + b) % 256; wr = 1; c = (a + b > 255); h = ((a % 16) + (b % 16) > 15);
        v = (((a >= 128) == (b >= 128)) && ((r >= 128) != (a >= 128)));
      end
      7: begin
        lo = a % 16; hi = a / 16;
        cl = (lo > 9) || (h == 1);
        ch = (hi > 9) || (c == 1) || (hi == 9 && lo > 9);
        r = (a + (cl ? 6 : 0) + (ch ? 96 : 0)) % 256; wr = 1;
        c = (c == 1 || ch) ? 1 : 0;
      end
      8: i = 1;
      9: i = 0;
      default: upd = 0;
    endcase
    if (o < 8) begin n = (r >= 128); z = (r == 0); end
    we = wr & e;
    nf = (e && upd) ? (192 + h*32 + i*16 + n*8 + z*4 + v*2 + c) : f;
  endfunction

  task automatic step(input int e, input int o, input int a, input int b, input string tag);
    int er, ew, ef;
    @(negedge clk);
    exec = e[0]; op = o[3:0]; opa = a[7:0]; opb = b[7:0];
    #1;
    model(e, o, a, b, m_ccr, er, ew, ef);
    chk({tag, " result"}, int'(result), er);
    chk({tag, " R3 write enable"}, int'(res_we), ew);
    @(posedge clk);
    #1;
    m_ccr = ef;
    chk({tag, " flags"}, int'(ccr), m_ccr);
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #20;
    chk("R1 reset flags", int'(ccr), 'hD0);
    @(negedge clk); rst_n = 1'b1;
    step(1, 9, 0, 0, "R9 clear I");
    step(1, 8, 0, 0, "R9 set I");
    step(1, 5, 'h45, 'h38, "R5 add");
    step(1, 7, 'h7D, 0, "R8 daa low fix");
    step(1, 5, 'h99, 'h01, "R5 add bcd");
    step(1, 7, 'h9A, 0, "R8 daa wrap");
    step(1, 5, 'h08, 'h08, "R5 half carry");
    step(1, 7, 'h10, 0, "R8 daa via H");
    step(1, 5, 'h7F, 'h01, "R5 overflow");
    step(1, 5, 'hFF, 'h01, "R5 carry zero");
    step(1, 6, 'h10, 'h20, "R6 sub borrow");
    step(1, 6, 'h80, 'h01, "R6 sub overflow");
    step(1, 4, 'h33, 'h33, "R6 cmp equal");
    step(1, 3, 'h80, 0, "R7 neg 0x80");
    step(1, 3, 'h00, 0, "R7 neg zero");
    step(1, 3, 'h01, 0, "R7 neg one");
    step(1, 0, 'hF0, 'h3C, "R4 and");
    step(1, 1, 'h00, 'h00, "R4 or zero");
    step(1, 2, 'hAA, 'h55, "R4 xor");
    step(0, 5, 'hFF, 'hFF, "R10 idle");
    step(1, 12, 'hFF, 'h01, "R10 unused code");
    step(1, 15, 'h00, 'h00, "R2 unused result");
    for (int k = 0; k < 600; k++) begin
      int ra, rb;
      ra = $urandom_range(0, 99);
      rb = $urandom_range(0, 99);
      if (k % 5 == 0) begin
        step(1, 5, (ra / 10) * 16 + ra % 10, (rb / 10) * 16 + rb % 10, "R5 bcd add");
        step(1, 7, int'(result), 0, "R8 bcd adjust");
      end else begin
        step(($urandom_range(0, 7) != 0) ? 1 : 0, $urandom_range(0, 15),
             $urandom_range(0, 255), $urandom_range(0, 255), "R11 random");
      end
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule